// File: doc/BRIEF.md
# Write-Through L1 Data Cache Line Controller

This block is the line-state controller of a small write-through level-one data cache inside a GPU compute unit. A request queue feeds it loads, stores, atomics, flush requests and invalidate requests, and it accepts them with a valid/ready handshake. Toward the level-two cache it issues block reads, write-throughs and forwarded atomics. It receives read fills, write acknowledgements and atomic results back. Each line is Invalid, Valid (read-only) or Atomic-pending, so the cache never holds modified data.

Every store is passed straight to level two. It carries its byte mask and the issuing instruction's sequence number. When the acknowledgement returns with that number, the controller reports write completion to the core. A disable input turns the array into a pass-through for read fills. Level two, the interconnect and any coherence directory sit outside the block.

Top module: `wtl1_ctrl`

## Requirements
- R1: After reset every line is Invalid, no completion or level-two request is raised, the flush flag is 0, and `req_ready_o` is 1 while no response is offered.
- R2: A load (op 0) that hits a Valid line completes one cycle after acceptance on `ld_done_o` with the stored data and issues nothing to level two. A load that misses issues a block read (kind 0) for its line address.
- R3: A read fill (response kind 0) raises `ld_done_o` with the returned data one cycle later. It allocates the line as Valid, taking the lowest Invalid way first and otherwise a way that is neither most-recently-used nor Atomic-pending.
- R4: A store (op 1) raises `st_done_o` with its sequence number and issues a write-through (kind 1) with its address, data, mask and sequence number. A line that was Valid becomes Invalid.
- R5: A write acknowledgement (response kind 1) raises `wr_cmp_o` one cycle later with the response's address and sequence number.
- R6: An atomic (op 2) to an Invalid or Valid line is sent to level two (kind 2) and leaves the line Atomic-pending. The atomic result (response kind 2) raises `atm_done_o` with the returned data and leaves the line Invalid.
- R7: A load, store or atomic to an Atomic-pending line holds `req_ready_o` low until the atomic result has arrived.
- R8: A flush (op 3) is accepted in any state and sets the sticky `flush_flag_o`. It raises no completion, sends nothing to level two and leaves line contents unchanged.
- R9: While a level-two response is offered, `req_ready_o` is 0, so responses always win over requests.
- R10: An invalidate (op 4) raises `inv_done_o`. It makes a Valid line Invalid and leaves an Atomic-pending line pending.
- R11: An atomic that misses in a set with no Invalid way first spends one cycle with `req_ready_o` low to invalidate the victim. The victim is a way that is neither most-recently-used nor Atomic-pending. The atomic is accepted in the following cycle.
- R12: With `disable_l1_i` high, a read fill completes the load without allocating, so a later load to that line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disable_l1_i | input | 1 | Read fills bypass the array |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_op_i | input | 3 | 0 load, 1 store, 2 atomic, 3 flush, 4 invalidate |
| req_addr_i | input | LADDR_W | Line address |
| req_data_i | input | DATA_W | Store data or atomic operand |
| req_mask_i | input | DATA_W/8 | Byte enables |
| req_seq_i | input | SEQ_W | Instruction sequence number |
| l2_req_valid_o | output | 1 | Level-two request issued |
| l2_req_kind_o | output | 2 | 0 read, 1 write-through, 2 atomic |
| l2_req_addr_o | output | LADDR_W | Request line address |
| l2_req_data_o | output | DATA_W | Request data |
| l2_req_mask_o | output | DATA_W/8 | Request byte enables |
| l2_req_seq_o | output | SEQ_W | Request sequence number |
| l2_rsp_valid_i | input | 1 | Level-two response offered |
| l2_rsp_kind_i | input | 2 | 0 read fill, 1 write ack, 2 atomic result |
| l2_rsp_addr_i | input | LADDR_W | Response line address |
| l2_rsp_data_i | input | DATA_W | Response data |
| l2_rsp_seq_i | input | SEQ_W | Response sequence number |
| ld_done_o | output | 1 | Load completed |
| st_done_o | output | 1 | Store accepted and forwarded |
| atm_done_o | output | 1 | Atomic completed |
| wr_cmp_o | output | 1 | Write-through acknowledged |
| inv_done_o | output | 1 | Invalidate completed |
| cpl_addr_o | output | LADDR_W | Completion address |
| cpl_data_o | output | DATA_W | Completion data |
| cpl_seq_o | output | SEQ_W | Completion sequence number |
| flush_flag_o | output | 1 | Sticky flush indication |

## Verification
A line left in the wrong state shows up at the next access to that line. A line wrongly left Valid returns a load hit where a block read was due. A line wrongly left Invalid emits a read where a hit was due. A line stuck in Atomic-pending stalls the queue head indefinitely. A wrong victim choice shows when a line that was touched recently misses on its next load. A sequence number that is lost or swapped appears on the write-through or on the completion raised one cycle after the acknowledgement.

// File: rtl/wtl1_pkg.sv
`timescale 1ns/1ps
package wtl1_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_VAL = 2'd1, LN_ATM = 2'd2} line_st_e;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_ATOMIC = 3'd2, OP_FLUSH = 3'd3, OP_INVAL = 3'd4
  } req_op_e;
  typedef enum logic [1:0] {L2_READ = 2'd0, L2_WRITE = 2'd1, L2_ATOMIC = 2'd2} l2_req_e;
  typedef enum logic [1:0] {RS_DATA = 2'd0, RS_WBACK = 2'd1, RS_ATOMIC = 2'd2} l2_rsp_e;
endpackage

// File: rtl/wtl1_store.sv
`timescale 1ns/1ps
module wtl1_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2,
  parameter int WAY_W  = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [SET_W-1:0]              rd_set_i,
  output logic [WAYS-1:0][1:0]          rd_st_o,
  output logic [WAYS-1:0][TAG_W-1:0]    rd_tag_o,
  output logic [WAYS-1:0][DATA_W-1:0]   rd_dat_o,
  output logic [WAY_W-1:0]              rd_mru_o,
  input  logic                          wr_en_i,
  input  logic [WAY_W-1:0]              wr_way_i,
  input  logic [1:0]                    wr_st_i,
  input  logic [TAG_W-1:0]              wr_tag_i,
  input  logic                          wr_dat_en_i,
  input  logic [DATA_W-1:0]             wr_dat_i,
  input  logic                          mru_en_i,
  input  logic [WAY_W-1:0]              mru_way_i
);
  logic [1:0]        st_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];
  logic [WAY_W-1:0]  mru_q [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_st_o[w]  = st_q[rd_set_i][w];
    assign rd_tag_o[w] = tag_q[rd_set_i][w];
    assign rd_dat_o[w] = dat_q[rd_set_i][w];
  end
  assign rd_mru_o = mru_q[rd_set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        mru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) st_q[s][w] <= 2'd0;
      end
    end else begin
      if (wr_en_i)  st_q[rd_set_i][wr_way_i] <= wr_st_i;
      if (mru_en_i) mru_q[rd_set_i] <= mru_way_i;
    end
  end

  // tags and data need no reset: state gates every use
  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[rd_set_i][wr_way_i] <= wr_tag_i;
    if (wr_en_i && wr_dat_en_i) dat_q[rd_set_i][wr_way_i] <= wr_dat_i;
  end
endmodule

// File: rtl/wtl1_lookup.sv
`timescale 1ns/1ps
module wtl1_lookup import wtl1_pkg::*; #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0][1:0]       st_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           look_tag_i,
  input  logic [WAY_W-1:0]           mru_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic [1:0]                 hit_st_o,
  output logic                       free_ok_o,
  output logic [WAY_W-1:0]           free_way_o,
  output logic                       vic_ok_o,
  output logic [WAY_W-1:0]           vic_way_o
);
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    hit_st_o   = LN_INV;
    free_ok_o  = 1'b0;
    free_way_o = '0;
    vic_ok_o   = 1'b0;
    vic_way_o  = '0;
    // fallback to the MRU way only when nothing else is usable
    if (st_i[mru_i] != LN_ATM) begin
      vic_ok_o  = 1'b1;
      vic_way_o = mru_i;
    end
    // descending scan: lowest index wins
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (st_i[i] != LN_INV && tag_i[i] == look_tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(i);
        hit_st_o  = st_i[i];
      end
      if (st_i[i] == LN_INV) begin
        free_ok_o  = 1'b1;
        free_way_o = WAY_W'(i);
      end
    end
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (WAY_W'(i) != mru_i && st_i[i] != LN_ATM) begin
        vic_ok_o  = 1'b1;
        vic_way_o = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/wtl1_ctrl.sv
`timescale 1ns/1ps
module wtl1_ctrl import wtl1_pkg::*; #(
  parameter int LADDR_W = 8,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int DATA_W  = 32,
  parameter int SEQ_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                disable_l1_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [2:0]          req_op_i,
  input  logic [LADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]   req_data_i,
  input  logic [DATA_W/8-1:0] req_mask_i,
  input  logic [SEQ_W-1:0]    req_seq_i,
  output logic                l2_req_valid_o,
  output logic [1:0]          l2_req_kind_o,
  output logic [LADDR_W-1:0]  l2_req_addr_o,
  output logic [DATA_W-1:0]   l2_req_data_o,
  output logic [DATA_W/8-1:0] l2_req_mask_o,
  output logic [SEQ_W-1:0]    l2_req_seq_o,
  input  logic                l2_rsp_valid_i,
  input  logic [1:0]          l2_rsp_kind_i,
  input  logic [LADDR_W-1:0]  l2_rsp_addr_i,
  input  logic [DATA_W-1:0]   l2_rsp_data_i,
  input  logic [SEQ_W-1:0]    l2_rsp_seq_i,
  output logic                ld_done_o,
  output logic                st_done_o,
  output logic                atm_done_o,
  output logic                wr_cmp_o,
  output logic                inv_done_o,
  output logic [LADDR_W-1:0]  cpl_addr_o,
  output logic [DATA_W-1:0]   cpl_data_o,
  output logic [SEQ_W-1:0]    cpl_seq_o,
  output logic                flush_flag_o
);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = LADDR_W - SET_W;
  localparam int MASK_W = DATA_W / 8;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [LADDR_W-1:0] look_addr;
  logic [SET_W-1:0]   look_set;
  logic [TAG_W-1:0]   look_tag;

  logic [WAYS-1:0][1:0]        rd_st;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][DATA_W-1:0] rd_dat;
  logic [WAY_W-1:0]            rd_mru;

  logic             hit, free_ok, vic_ok;
  logic [WAY_W-1:0] hit_way, free_way, vic_way;
  logic [1:0]       hit_st;

  logic             wr_en, wr_dat_en, mru_en, accept, flush_set;
  logic [WAY_W-1:0] wr_way, mru_way;
  logic [1:0]       wr_st;

  logic               e_ld, e_st, e_atm, e_wc, e_inv;
  logic [DATA_W-1:0]  e_data;
  logic [SEQ_W-1:0]   e_seq;
  logic               q_v;
  logic [1:0]         q_kind;

  assign look_addr = l2_rsp_valid_i ? l2_rsp_addr_i : req_addr_i;
  assign look_set  = look_addr[SET_W-1:0];
  assign look_tag  = look_addr[LADDR_W-1:SET_W];

  wtl1_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_store (
    .clk_i, .rst_ni,
    .rd_set_i(look_set), .rd_st_o(rd_st), .rd_tag_o(rd_tag), .rd_dat_o(rd_dat),
    .rd_mru_o(rd_mru),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_st_i(wr_st), .wr_tag_i(look_tag),
    .wr_dat_en_i(wr_dat_en), .wr_dat_i(l2_rsp_data_i),
    .mru_en_i(mru_en), .mru_way_i(mru_way)
  );

  wtl1_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
    .st_i(rd_st), .tag_i(rd_tag), .look_tag_i(look_tag), .mru_i(rd_mru),
    .hit_o(hit), .hit_way_o(hit_way), .hit_st_o(hit_st),
    .free_ok_o(free_ok), .free_way_o(free_way),
    .vic_ok_o(vic_ok), .vic_way_o(vic_way)
  );

  always_comb begin
    wr_en = 1'b0; wr_dat_en = 1'b0; wr_way = hit_way; wr_st = LN_INV;
    mru_en = 1'b0; mru_way = hit_way;
    accept = 1'b0; flush_set = 1'b0;
    e_ld = 1'b0; e_st = 1'b0; e_atm = 1'b0; e_wc = 1'b0; e_inv = 1'b0;
    e_data = '0; e_seq = '0;
    q_v = 1'b0; q_kind = L2_READ;
    if (l2_rsp_valid_i) begin
      unique case (l2_rsp_e'(l2_rsp_kind_i))
        RS_DATA: begin
          e_ld = 1'b1;
          e_data = l2_rsp_data_i;
          if (!disable_l1_i) begin
            if (hit) begin
              if (hit_st == LN_VAL) begin
                wr_en = 1'b1; wr_st = LN_VAL; wr_dat_en = 1'b1; mru_en = 1'b1;
              end
            end else if (free_ok) begin
              wr_en = 1'b1; wr_way = free_way; wr_st = LN_VAL; wr_dat_en = 1'b1;
              mru_en = 1'b1; mru_way = free_way;
            end else if (vic_ok) begin
              // fills cannot wait, so the victim is overwritten in place
              wr_en = 1'b1; wr_way = vic_way; wr_st = LN_VAL; wr_dat_en = 1'b1;
              mru_en = 1'b1; mru_way = vic_way;
            end
          end
        end
        RS_WBACK: begin
          e_wc = 1'b1;
          e_seq = l2_rsp_seq_i;
        end
        RS_ATOMIC: begin
          e_atm = 1'b1;
          e_data = l2_rsp_data_i;
          if (hit && hit_st == LN_ATM) begin
            wr_en = 1'b1; wr_st = LN_INV;
          end
        end
        default: ;
      endcase
    end else if (req_valid_i) begin
      unique case (req_op_e'(req_op_i))
        OP_LOAD: if (!(hit && hit_st == LN_ATM)) begin
          accept = 1'b1;
          if (hit) begin
            e_ld = 1'b1; e_data = rd_dat[hit_way]; mru_en = 1'b1;
          end else begin
            q_v = 1'b1; q_kind = L2_READ;
          end
        end
        OP_STORE: if (!(hit && hit_st == LN_ATM)) begin
          accept = 1'b1;
          e_st = 1'b1; e_seq = req_seq_i;
          q_v = 1'b1; q_kind = L2_WRITE;
          if (hit) begin
            wr_en = 1'b1; wr_st = LN_INV;
          end
        end
        OP_ATOMIC: if (!(hit && hit_st == LN_ATM)) begin
          if (hit) begin
            accept = 1'b1; wr_en = 1'b1; wr_st = LN_ATM; mru_en = 1'b1;
            q_v = 1'b1; q_kind = L2_ATOMIC;
          end else if (free_ok) begin
            accept = 1'b1; wr_en = 1'b1; wr_way = free_way; wr_st = LN_ATM;
            mru_en = 1'b1; mru_way = free_way;
            q_v = 1'b1; q_kind = L2_ATOMIC;
          end else if (vic_ok) begin
            // replacement cycle: drop the victim, retry next cycle
            wr_en = 1'b1; wr_way = vic_way; wr_st = LN_INV;
          end
        end
        OP_FLUSH: begin
          accept = 1'b1; flush_set = 1'b1;
        end
        OP_INVAL: begin
          accept = 1'b1; e_inv = 1'b1;
          if (hit && hit_st == LN_VAL) begin
            wr_en = 1'b1; wr_st = LN_INV;
          end
        end
        default: accept = 1'b1;
      endcase
    end
  end

  assign req_ready_o = l2_rsp_valid_i ? 1'b0 : (req_valid_i ? accept : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_done_o <= 1'b0; st_done_o <= 1'b0; atm_done_o <= 1'b0;
      wr_cmp_o <= 1'b0; inv_done_o <= 1'b0;
      cpl_addr_o <= '0; cpl_data_o <= '0; cpl_seq_o <= '0;
      l2_req_valid_o <= 1'b0; l2_req_kind_o <= '0; l2_req_addr_o <= '0;
      l2_req_data_o <= '0; l2_req_mask_o <= '0; l2_req_seq_o <= '0;
      flush_flag_o <= 1'b0;
    end else begin
      ld_done_o  <= e_ld;
      st_done_o  <= e_st;
      atm_done_o <= e_atm;
      wr_cmp_o   <= e_wc;
      inv_done_o <= e_inv;
      cpl_addr_o <= look_addr;
      cpl_data_o <= e_data;
      cpl_seq_o  <= e_seq;
      l2_req_valid_o <= q_v;
      l2_req_kind_o  <= q_kind;
      l2_req_addr_o  <= req_addr_i;
      l2_req_data_o  <= q_v ? req_data_i : '0;
      l2_req_mask_o  <= q_v ? req_mask_i : MASK_W'(0);
      l2_req_seq_o   <= q_v ? req_seq_i : '0;
      if (flush_set) flush_flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wtl1_ctrl_chk.sv
`timescale 1ns/1ps
module wtl1_ctrl_chk import wtl1_pkg::*; #(
  parameter int SEQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [2:0]       req_op_i,
  input logic [SEQ_W-1:0] req_seq_i,
  input logic             l2_req_valid_o,
  input logic [1:0]       l2_req_kind_o,
  input logic [SEQ_W-1:0] l2_req_seq_o,
  input logic             l2_rsp_valid_i,
  input logic [1:0]       l2_rsp_kind_i,
  input logic [SEQ_W-1:0] l2_rsp_seq_i,
  input logic             ld_done_o,
  input logic             st_done_o,
  input logic             atm_done_o,
  input logic             wr_cmp_o,
  input logic             inv_done_o,
  input logic [SEQ_W-1:0] cpl_seq_o,
  input logic             flush_flag_o
);
  AST_RSP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_rsp_valid_i |-> !req_ready_o); // R9

  AST_WT_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == OP_STORE) |=>
      (l2_req_valid_o && l2_req_kind_o == L2_WRITE && l2_req_seq_o == $past(req_seq_i))); // R4

  AST_ST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o |-> (cpl_seq_o == $past(req_seq_i) && $past(req_valid_i && req_ready_o))); // R4

  AST_WCMP_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp_o |-> ($past(l2_rsp_valid_i && l2_rsp_kind_i == RS_WBACK) &&
                  cpl_seq_o == $past(l2_rsp_seq_i))); // R5

  AST_ATM_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atm_done_o |-> $past(l2_rsp_valid_i && l2_rsp_kind_i == RS_ATOMIC)); // R6

  AST_ONE_CPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_done_o, st_done_o, atm_done_o, wr_cmp_o, inv_done_o})); // R9

  AST_FLUSH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(flush_flag_o)); // R8
endmodule

bind wtl1_ctrl wtl1_ctrl_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_op_i(req_op_i), .req_seq_i(req_seq_i), .l2_req_valid_o(l2_req_valid_o),
  .l2_req_kind_o(l2_req_kind_o), .l2_req_seq_o(l2_req_seq_o),
  .l2_rsp_valid_i(l2_rsp_valid_i), .l2_rsp_kind_i(l2_rsp_kind_i), .l2_rsp_seq_i(l2_rsp_seq_i),
  .ld_done_o(ld_done_o), .st_done_o(st_done_o), .atm_done_o(atm_done_o),
  .wr_cmp_o(wr_cmp_o), .inv_done_o(inv_done_o), .cpl_seq_o(cpl_seq_o),
  .flush_flag_o(flush_flag_o)
);

// File: tb/sim_wtl1_ctrl.sv
`timescale 1ns/1ps
module sim_wtl1_ctrl;
  localparam int K_LD = 1, K_ST = 2, K_ATM = 3, K_WC = 4, K_INV = 5, K_RD = 6, K_WR = 7, K_AT = 8;

  typedef struct {
    int         kind;
    logic [7:0] addr;
    logic [31:0] data;
    logic [3:0] mask;
    logic [7:0] seq;
    string      req;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0, dis = 1'b0;
  logic rq_v = 1'b0, rdy;
  logic [2:0] rq_op = '0;
  logic [7:0] rq_a = '0, rq_s = '0;
  logic [31:0] rq_d = '0;
  logic [3:0] rq_m = '0;
  logic q_v; logic [1:0] q_k; logic [7:0] q_a, q_s; logic [31:0] q_d; logic [3:0] q_m;
  logic rs_v = 1'b0; logic [1:0] rs_k = '0; logic [7:0] rs_a = '0, rs_s = '0; logic [31:0] rs_d = '0;
  logic ld, st, at, wc, iv, ff;
  logic [7:0] c_a, c_s; logic [31:0] c_d;

  int checks = 0, fails = 0;
  ev_t expq[$];

  always #2 clk = ~clk;

  wtl1_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .disable_l1_i(dis),
    .req_valid_i(rq_v), .req_ready_o(rdy), .req_op_i(rq_op), .req_addr_i(rq_a),
    .req_data_i(rq_d), .req_mask_i(rq_m), .req_seq_i(rq_s),
    .l2_req_valid_o(q_v), .l2_req_kind_o(q_k), .l2_req_addr_o(q_a), .l2_req_data_o(q_d),
    .l2_req_mask_o(q_m), .l2_req_seq_o(q_s),
    .l2_rsp_valid_i(rs_v), .l2_rsp_kind_i(rs_k), .l2_rsp_addr_i(rs_a), .l2_rsp_data_i(rs_d),
    .l2_rsp_seq_i(rs_s),
    .ld_done_o(ld), .st_done_o(st), .atm_done_o(at), .wr_cmp_o(wc), .inv_done_o(iv),
    .cpl_addr_o(c_a), .cpl_data_o(c_d), .cpl_seq_o(c_s), .flush_flag_o(ff)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input logic [7:0] a, input logic [31:0] d,
                           input logic [3:0] m, input logic [7:0] s, input string req);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d; e.mask = m; e.seq = s; e.req = req;
    expq.push_back(e);
  endtask

  task automatic observe(input int k, input logic [7:0] a, input logic [31:0] d,
                         input logic [3:0] m, input logic [7:0] s);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL unexpected kind=%0d addr=%0h actual=%0h expected=none", k, a, d);
      return;
    end
    e = expq.pop_front();
    if (e.kind != k || e.addr != a || e.data != d || e.mask != m || e.seq != s) begin
      fails++;
      $display("FAIL %s actual k=%0d a=%0h d=%0h m=%0h s=%0h expected k=%0d a=%0h d=%0h m=%0h s=%0h",
               e.req, k, a, d, m, s, e.kind, e.addr, e.data, e.mask, e.seq);
    end
  endtask

  // monitor: completions first, then level-two requests, each cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (ld) observe(K_LD, c_a, c_d, 4'h0, 8'h0);
      if (st) observe(K_ST, c_a, 32'h0, 4'h0, c_s);
      if (at) observe(K_ATM, c_a, c_d, 4'h0, 8'h0);
      if (wc) observe(K_WC, c_a, 32'h0, 4'h0, c_s);
      if (iv) observe(K_INV, c_a, 32'h0, 4'h0, 8'h0);
      if (q_v) begin
        if (q_k == 2'd0) observe(K_RD, q_a, 32'h0, 4'h0, 8'h0);
        else if (q_k == 2'd1) observe(K_WR, q_a, q_d, q_m, q_s);
        else observe(K_AT, q_a, q_d, q_m, q_s);
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] m, input logic [7:0] s, output int waits);
    @(negedge clk);
    rq_v = 1'b1; rq_op = op; rq_a = a; rq_d = d; rq_m = m; rq_s = s;
    waits = 0;
    #1;
    while (!rdy) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rq_v = 1'b0;
  endtask

  task automatic respond(input logic [1:0] k, input logic [7:0] a, input logic [31:0] d,
                         input logic [7:0] s);
    @(negedge clk);
    rs_v = 1'b1; rs_k = k; rs_a = a; rs_d = d; rs_s = s;
    #1;
    chk(rdy == 1'b0, "R9 ready during response", rdy, 0);
    @(negedge clk);
    rs_v = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({ld, st, at, wc, iv, q_v} == 6'b0, "R1 no events after reset", {ld, st, at, wc, iv, q_v}, 0);
    chk(ff == 1'b0, "R1 flush flag", ff, 0);
    chk(rdy == 1'b1, "R1 ready", rdy, 1);

    // R1/R2: cold miss, fill, then hit
    expect_ev(K_RD, 8'h10, 0, 0, 0, "R1 cold load misses");
    send(3'd0, 8'h10, 0, 0, 8'h01, w);
    expect_ev(K_LD, 8'h10, 32'hA1A1_0001, 0, 0, "R3 fill completes load");
    respond(2'd0, 8'h10, 32'hA1A1_0001, 0);
    expect_ev(K_LD, 8'h10, 32'hA1A1_0001, 0, 0, "R2 load hit");
    send(3'd0, 8'h10, 0, 0, 8'h02, w);

    // R4: store to a valid line, then load misses
    expect_ev(K_ST, 8'h10, 0, 0, 8'h05, "R4 store done");
    expect_ev(K_WR, 8'h10, 32'h1234_5678, 4'h6, 8'h05, "R4 write-through");
    send(3'd1, 8'h10, 32'h1234_5678, 4'h6, 8'h05, w);
    expect_ev(K_RD, 8'h10, 0, 0, 0, "R4 line invalid after store");
    send(3'd0, 8'h10, 0, 0, 8'h03, w);
    expect_ev(K_WC, 8'h10, 0, 0, 8'h05, "R5 write complete");
    respond(2'd1, 8'h10, 0, 8'h05);
    expect_ev(K_LD, 8'h10, 32'hA1A1_0002, 0, 0, "R3 refill");
    respond(2'd0, 8'h10, 32'hA1A1_0002, 0);

    // R4: store to an invalid line, then load misses
    expect_ev(K_ST, 8'h20, 0, 0, 8'h06, "R4 store miss done");
    expect_ev(K_WR, 8'h20, 32'hCAFE_0000, 4'hF, 8'h06, "R4 store miss write-through");
    send(3'd1, 8'h20, 32'hCAFE_0000, 4'hF, 8'h06, w);
    expect_ev(K_RD, 8'h20, 0, 0, 0, "R4 no allocation on store");
    send(3'd0, 8'h20, 0, 0, 8'h07, w);
    expect_ev(K_LD, 8'h20, 32'hB0B0_0003, 0, 0, "R3 fill second way");
    respond(2'd0, 8'h20, 32'hB0B0_0003, 0);

    // R11: atomic miss on a full set costs one replacement cycle
    expect_ev(K_AT, 8'h14, 32'h0000_0009, 4'hF, 8'h08, "R6 atomic forwarded");
    send(3'd2, 8'h14, 32'h0000_0009, 4'hF, 8'h08, w);
    chk(w == 1, "R11 replacement cycle", w, 1);
    expect_ev(K_LD, 8'h20, 32'hB0B0_0003, 0, 0, "R11 MRU way kept");
    send(3'd0, 8'h20, 0, 0, 8'h09, w);
    expect_ev(K_RD, 8'h10, 0, 0, 0, "R11 victim evicted");
    send(3'd0, 8'h10, 0, 0, 8'h0A, w);

    // R7: load to pending line stalls until the atomic result
    expect_ev(K_ATM, 8'h14, 32'h7777_0001, 0, 0, "R6 atomic done");
    expect_ev(K_RD, 8'h14, 0, 0, 0, "R6 line invalid after atomic");
    fork
      begin
        int w2;
        send(3'd0, 8'h14, 0, 0, 8'h0B, w2);
      end
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(rdy == 1'b0, "R7 stall on pending line", rdy, 0);
        respond(2'd2, 8'h14, 32'h7777_0001, 0);
      end
    join

    // R10: invalidate on pending line leaves it pending
    expect_ev(K_AT, 8'h20, 32'h0000_0002, 4'hF, 8'h0C, "R6 atomic on valid line");
    send(3'd2, 8'h20, 32'h0000_0002, 4'hF, 8'h0C, w);
    expect_ev(K_INV, 8'h20, 0, 0, 0, "R10 invalidate pending done");
    send(3'd4, 8'h20, 0, 0, 0, w);
    expect_ev(K_ATM, 8'h20, 32'h7777_0002, 0, 0, "R6 atomic done 2");
    expect_ev(K_RD, 8'h20, 0, 0, 0, "R10 pending kept then invalid");
    fork
      begin
        int w3;
        send(3'd1 - 3'd1, 8'h20, 0, 0, 8'h0D, w3);
      end
      begin
        repeat (2) @(negedge clk);
        #1;
        chk(rdy == 1'b0, "R10 line still pending", rdy, 0);
        respond(2'd2, 8'h20, 32'h7777_0002, 0);
      end
    join

    // R10: invalidate of a valid line
    expect_ev(K_RD, 8'h31, 0, 0, 0, "R2 miss set 1");
    send(3'd0, 8'h31, 0, 0, 0, w);
    expect_ev(K_LD, 8'h31, 32'hD4D4_0004, 0, 0, "R3 fill set 1");
    respond(2'd0, 8'h31, 32'hD4D4_0004, 0);
    expect_ev(K_LD, 8'h31, 32'hD4D4_0004, 0, 0, "R2 hit set 1");
    send(3'd0, 8'h31, 0, 0, 0, w);
    expect_ev(K_INV, 8'h31, 0, 0, 0, "R10 invalidate valid");
    send(3'd4, 8'h31, 0, 0, 0, w);
    expect_ev(K_RD, 8'h31, 0, 0, 0, "R10 line invalid after invalidate");
    send(3'd0, 8'h31, 0, 0, 0, w);

    // R8: flush only sets the flag
    expect_ev(K_RD, 8'h05, 0, 0, 0, "R2 miss 0x05");
    send(3'd0, 8'h05, 0, 0, 0, w);
    expect_ev(K_LD, 8'h05, 32'hE5E5_0005, 0, 0, "R3 fill 0x05");
    respond(2'd0, 8'h05, 32'hE5E5_0005, 0);
    send(3'd3, 8'h05, 0, 0, 0, w);
    chk(ff == 1'b1, "R8 flush flag set", ff, 1);
    expect_ev(K_LD, 8'h05, 32'hE5E5_0005, 0, 0, "R8 line kept after flush");
    send(3'd0, 8'h05, 0, 0, 0, w);

    // R12: disabled array bypasses fills
    dis = 1'b1;
    expect_ev(K_RD, 8'h07, 0, 0, 0, "R12 miss with disable");
    send(3'd0, 8'h07, 0, 0, 0, w);
    expect_ev(K_LD, 8'h07, 32'hF6F6_0006, 0, 0, "R12 bypass data");
    respond(2'd0, 8'h07, 32'hF6F6_0006, 0);
    dis = 1'b0;
    expect_ev(K_RD, 8'h07, 0, 0, 0, "R12 not allocated");
    send(3'd0, 8'h07, 0, 0, 0, w);

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R2 all expected events seen", expq.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule